// File: doc/BRIEF.md
# Conversion Result Block Transfer Controller

This block sits beside an analogue-to-digital converter and copies every finished conversion result into a region of word-addressed memory, so that no processor has to collect the results. Each result-valid pulse from the converter produces exactly one memory write, with an address, the 16-bit data word and a one-cycle write strobe. During that same cycle the block raises a stall request so that the processor keeps off the memory port.

Software sets a start address, a count of transfers per block, a choice between one block and two alternating blocks, and a continuous-transfer enable. When the last word of a block is written, the block pulses a completion flag and records which of the two blocks it has just filled. In two-block mode one block can be read while the other fills. With continuous transfer off, the block stops once its block or blocks are full. With it on, it wraps back to the start address and keeps going. A count of zero switches the block off. When the count or the start address changes, the pointer and the counter load again from the new values.

Top module: `res_xfer_ctrl`

## Requirements
- R1: While the transfer count is 0, result-valid pulses cause no write strobe, no stall request and no completion flag.
- R2: In one-block mode the k-th result after a reload (k = 0 .. n-1) is written to address S + 2k, where S is the start address with bit 0 cleared and n is the count.
- R3: In two-block mode, results 0 .. n-1 go to S .. S+2n-2 (block 1) and results n .. 2n-1 go to S+2n .. S+4n-2 (block 2).
- R4: Bit 0 of the start address is ignored, so every write address is even.
- R5: With continuous transfer off, once the last block is full, further result-valid pulses produce no write until the count or the start address changes.
- R6: With continuous transfer on, the result after the last word of the last block is written to S again and the block sequence restarts at block 1.
- R7: `blk_done` is high for one cycle, together with the write of the final word of each block, and is low for every other write.
- R8: Each accepted result-valid pulse, sampled at a rising edge, sets `mem_we` and `stall_req` high for exactly the following cycle, and `mem_wdata` carries the result data. Both are low after reset.
- R9: A change of the count or of the start address discards a partly filled block: the next result goes to the new S, in block 1, and a full n results are needed before the next completion.
- R10: `last_block_first` is 0 after reset. It becomes 1 when block 1 completes and 0 when block 2 completes. A reload leaves it unchanged, and so does a write that does not complete a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base_addr | input | AW (16) | Start byte address; bit 0 ignored |
| cfg_xfer_count | input | CW (8) | Transfers per block; 0 disables |
| cfg_two_block | input | 1 | 1 selects two alternating blocks |
| cfg_continuous | input | 1 | 1 wraps to the start address indefinitely |
| res_valid | input | 1 | One-cycle pulse: a conversion result is ready |
| res_data | input | DW (16) | Conversion result word |
| mem_addr | output | AW (16) | Write byte address |
| mem_wdata | output | DW (16) | Write data |
| mem_we | output | 1 | Write strobe, one cycle per transfer |
| stall_req | output | 1 | Processor stall request during a transfer |
| blk_done | output | 1 | Block-complete pulse |
| last_block_first | output | 1 | 1: block 1 filled last; 0: block 2 filled last |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit count and 16-bit data. With these widths the largest count, 255, fits in a short run, and the bench drives a full 255-word block and then confirms that the next pulse is dropped. The table covers counts of 0, 1, 2, 3, 4 and 5 in every mix of block mode and continuous mode, and an odd start address. The small counts make both two-block alternation and the continuous wrap happen several times within a few pulses. Directed cases change the address and then the count in the middle of a block, to show that the partly filled block is discarded.

// File: rtl/res_xfer_pkg.sv
package res_xfer_pkg;

    // Which block the sequencer is currently filling.
    typedef enum logic {
        BLK_FIRST  = 1'b0,
        BLK_SECOND = 1'b1
    } blk_sel_e;

endpackage

// File: rtl/res_xfer_cfg_watch.sv
module res_xfer_cfg_watch #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_base,
    input  logic [CW-1:0] cfg_count,
    output logic          reload,
    output logic [AW-2:0] base_q,
    output logic [CW-1:0] count_q
);

    typedef struct packed {
        logic [AW-2:0] base;   // upper bits only: bit 0 is never stored
        logic [CW-1:0] count;
    } cfg_t;

    cfg_t st_d, st_q;
    logic unused_base_lsb;

    assign unused_base_lsb = cfg_base[0];

    always_comb begin
        st_d.base  = cfg_base[AW-1:1];
        st_d.count = cfg_count;
        reload     = (st_d != st_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_q  = st_q.base;
    assign count_q = st_q.count;

    // After any edge the shadow copy matches what was applied before it.
    AST_SHADOW_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reload) |-> (count_q == $past(cfg_count)));  // R9

endmodule

// File: rtl/res_xfer_seq.sv
module res_xfer_seq
    import res_xfer_pkg::*;
#(
    parameter int CW = 8,
    parameter int PW = CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          res_valid,
    input  logic          reload,
    input  logic [CW-1:0] new_count,
    input  logic [CW-1:0] count_q,
    input  logic          two_block,
    input  logic          continuous,
    output logic          fire,
    output logic [PW-1:0] ptr,
    output logic          done,
    output logic          last_first,
    output logic          stall
);

    typedef struct packed {
        logic [PW-1:0] ptr;    // word offset from the start address
        logic [CW-1:0] cnt;    // words still to write in the current block
        blk_sel_e      blk;
        logic          halt;   // non-continuous run finished
        logic          done;
        logic          last;
        logic          stall;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.stall = 1'b0;
        fire       = res_valid && !reload && (st_q.cnt != '0) && !st_q.halt;

        if (reload) begin
            st_d.ptr  = '0;
            st_d.cnt  = new_count;
            st_d.blk  = BLK_FIRST;
            st_d.halt = 1'b0;
        end else if (fire) begin
            st_d.stall = 1'b1;
            if (st_q.cnt == CW'(1)) begin
                st_d.done = 1'b1;
                st_d.last = (st_q.blk == BLK_FIRST);
                st_d.cnt  = count_q;
                if (two_block && st_q.blk == BLK_FIRST) begin
                    st_d.blk = BLK_SECOND;
                    st_d.ptr = st_q.ptr + 1'b1;
                end else begin
                    st_d.blk  = BLK_FIRST;
                    st_d.ptr  = '0;
                    st_d.halt = !continuous;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr        = st_q.ptr;
    assign done       = st_q.done;
    assign last_first = st_q.last;
    assign stall      = st_q.stall;

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.halt && !reload) |=> !st_q.stall);  // R5

    AST_LAST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.done |-> $stable(st_q.last));  // R10

    AST_RELOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (st_q.ptr == '0 && !st_q.halt && st_q.blk == BLK_FIRST));  // R9

endmodule

// File: rtl/res_xfer_port.sv
module res_xfer_port #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int PW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [PW-1:0] ptr,
    input  logic [AW-2:0] base_q,
    input  logic [DW-1:0] res_data,
    output logic          we,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata
);

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } port_t;

    port_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.we = fire;
        if (fire) begin
            st_d.addr = {base_q, 1'b0} + AW'({ptr, 1'b0});
            st_d.data = res_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign we    = st_q.we;
    assign addr  = st_q.addr;
    assign wdata = st_q.data;

    AST_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !addr[0]);  // R4

endmodule

// File: rtl/res_xfer_ctrl.sv
module res_xfer_ctrl #(
    parameter int AW = 16,
    parameter int CW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_base_addr,
    input  logic [CW-1:0] cfg_xfer_count,
    input  logic          cfg_two_block,
    input  logic          cfg_continuous,
    input  logic          res_valid,
    input  logic [DW-1:0] res_data,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          stall_req,
    output logic          blk_done,
    output logic          last_block_first
);

    // Two blocks of at most 2^CW-1 words need one more pointer bit.
    localparam int PW = CW + 1;

    logic          reload;
    logic [AW-2:0] base_q;
    logic [CW-1:0] count_q;
    logic          fire;
    logic [PW-1:0] ptr;

    res_xfer_cfg_watch #(.AW(AW), .CW(CW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_base  (cfg_base_addr),
        .cfg_count (cfg_xfer_count),
        .reload    (reload),
        .base_q    (base_q),
        .count_q   (count_q)
    );

    res_xfer_seq #(.CW(CW), .PW(PW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .res_valid  (res_valid),
        .reload     (reload),
        .new_count  (cfg_xfer_count),
        .count_q    (count_q),
        .two_block  (cfg_two_block),
        .continuous (cfg_continuous),
        .fire       (fire),
        .ptr        (ptr),
        .done       (blk_done),
        .last_first (last_block_first),
        .stall      (stall_req)
    );

    res_xfer_port #(.AW(AW), .DW(DW), .PW(PW)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .ptr      (ptr),
        .base_q   (base_q),
        .res_data (res_data),
        .we       (mem_we),
        .addr     (mem_addr),
        .wdata    (mem_wdata)
    );

    AST_STALL_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we == stall_req);  // R8

    AST_OFF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(|cfg_xfer_count) |-> !mem_we);  // R1

    AST_DONE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> mem_we);  // R7

endmodule

// File: tb/res_xfer_ctrl_test.sv
module res_xfer_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_base_addr = '0;
    logic [7:0]  cfg_xfer_count = '0;
    logic        cfg_two_block = 1'b0;
    logic        cfg_continuous = 1'b0;
    logic        res_valid = 1'b0;
    logic [15:0] res_data = '0;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_we, stall_req, blk_done, last_block_first;

    always #2 clk = ~clk;  // 250 MHz

    res_xfer_ctrl uut (.*);

    int n_tests = 0;
    int n_fail = 0;
    int seq_no = 0;
    int n_done_seen = 0;
    bit finished = 0;

    // Reference model state
    logic [15:0] m_base;
    int          m_n, m_k;
    bit          m_dual, m_loop;
    logic        m_last = 1'b0;

    localparam int NV = 6;
    localparam logic [15:0] V_BASE [NV] = '{16'h1000, 16'h2001, 16'h0100, 16'h3000, 16'hFFF0, 16'h4000};
    localparam int          V_N    [NV] = '{4, 3, 2, 1, 5, 0};
    localparam bit          V_DUAL [NV] = '{0, 1, 1, 0, 0, 1};
    localparam bit          V_LOOP [NV] = '{0, 0, 1, 1, 1, 1};
    localparam int          V_PULS [NV] = '{6, 8, 9, 3, 12, 3};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply_cfg(input logic [15:0] b, input int n, input bit dual, input bit lp);
        @(negedge clk) cfg_xfer_count = '0;
        @(negedge clk);
        cfg_base_addr = b; cfg_xfer_count = 8'(n);
        cfg_two_block = dual; cfg_continuous = lp;
        @(negedge clk);
        m_base = b; m_n = n; m_dual = dual; m_loop = lp; m_k = 0;
    endtask

    task automatic do_pulse();
        int total, idx;
        bit we_exp, done_exp;
        logic [15:0] a_exp, d;
        string s_tag, a_tag;
        d = 16'h1357 ^ 16'(seq_no * 16'h0307);
        seq_no++;
        @(negedge clk) begin res_valid = 1'b1; res_data = d; end
        @(negedge clk) res_valid = 1'b0;
        total    = m_dual ? 2 * m_n : m_n;
        we_exp   = (m_n != 0) && (m_loop || m_k < total);
        done_exp = 1'b0;
        idx      = 0;
        a_exp    = '0;
        a_tag    = "R2";
        if (we_exp) begin
            idx      = m_k % total;
            a_exp    = (m_base & 16'hFFFE) + 16'(2 * idx);
            done_exp = (idx % m_n) == m_n - 1;
            if (done_exp) m_last = (idx < m_n);
            if (m_k >= total)   a_tag = "R6";
            else if (idx >= m_n) a_tag = "R3";
        end
        s_tag = we_exp ? "R8" : (m_n == 0 ? "R1" : "R5");
        m_k++;
        if (blk_done) n_done_seen++;
        chk({s_tag, " strobe"}, {31'd0, mem_we}, {31'd0, we_exp});
        chk({s_tag, " stall"}, {31'd0, stall_req}, {31'd0, we_exp});
        if (we_exp) begin
            chk({a_tag, " address"}, {16'd0, mem_addr}, {16'd0, a_exp});
            chk("R4 even address", {31'd0, mem_addr[0]}, 32'd0);
            chk("R8 data", {16'd0, mem_wdata}, {16'd0, d});
        end
        chk("R7 block done", {31'd0, blk_done}, {31'd0, done_exp});
        chk("R10 last block", {31'd0, last_block_first}, {31'd0, m_last});
        @(negedge clk);
        chk("R8 strobe one cycle", {29'd0, mem_we, stall_req, blk_done}, 32'd0);
    endtask

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset strobe", {30'd0, mem_we, stall_req}, 32'd0);
        chk("R7 reset done", {31'd0, blk_done}, 32'd0);
        chk("R10 reset last", {31'd0, last_block_first}, 32'd0);

        // Table-driven runs
        for (int v = 0; v < NV; v++) begin
            apply_cfg(V_BASE[v], V_N[v], V_DUAL[v], V_LOOP[v]);
            for (int p = 0; p < V_PULS[v]; p++) do_pulse();
        end

        // R9: start address change in the middle of a block
        apply_cfg(16'h5000, 4, 0, 0);
        do_pulse(); do_pulse();
        @(negedge clk) cfg_base_addr = 16'h6000;
        @(negedge clk);
        m_base = 16'h6000; m_k = 0;
        d0 = n_done_seen;
        do_pulse();
        chk("R9 restart address", {16'd0, mem_addr}, 32'h6000);
        do_pulse(); do_pulse();
        chk("R9 no early completion", n_done_seen, d0);
        do_pulse();
        chk("R9 full block after reload", n_done_seen, d0 + 1);

        // R9: count change alone in the middle of a two-block run
        apply_cfg(16'h7000, 3, 1, 1);
        do_pulse();
        @(negedge clk) cfg_xfer_count = 8'd2;
        @(negedge clk);
        m_n = 2; m_k = 0;
        do_pulse();
        chk("R9 count reload address", {16'd0, mem_addr}, 32'h7000);
        do_pulse(); do_pulse(); do_pulse();

        // Largest count, one block, then the run stops
        apply_cfg(16'h0800, 255, 0, 0);
        for (int p = 0; p < 255; p++) do_pulse();
        chk("R2 last word of 255", {16'd0, mem_addr}, 32'h09FC);
        do_pulse();
        chk("R5 stopped after 255", {31'd0, last_block_first}, 32'd1);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule